// File: doc/BRIEF.md
# Byte-Serial Instruction Sequencer

This block is the control state machine of a small non-pipelined processor whose instructions are 16 bits wide but reach it over an 8-bit data bus. It owns the 16-bit program counter and the memory read strobe. It assembles each instruction from two consecutive bytes. When the operand types call for it, it pulls one more byte that holds an immediate value or an address. It then spends one cycle on an execute step with an ALU start pulse, and one or two cycles on register-file write enables, before it fetches again. A halt opcode freezes it until reset.

Each state lasts exactly one clock. Memory is expected to answer a read in the same cycle, so the byte on the read-data port is captured at the rising edge that ends each fetch state. The operand-type fields sit in the first instruction byte. The route after the second fetch is therefore known without a separate decode cycle.

Top module: `instr_seq`

## Requirements
- R1: While the active-low reset is low (asynchronously), the program counter is 0x0000 and the state indicator is 0. In the first cycle after reset rises, the read strobe is high with address 0x0000.
- R2: Every instruction starts with two fetch cycles: state 0 captures the byte at the program counter into instruction bits [15:8], and state 1 captures the next byte into bits [7:0].
- R3: Instruction fields are: opcode [15:11], source type [10:9] (00 register, 01 memory, 10 immediate, 11 condition), destination type [8] (0 register, 1 memory), source address [7:5], destination address [4:2], condition [1:0]. An operand byte is fetched when the source type is 01 or 10 or the destination type is 1.
- R4: The operand byte is read at the program counter in state 2 and appears on the operand output. Each cycle with the read strobe high advances the program counter by exactly one; other cycles leave it unchanged.
- R5: Every instruction other than NOP and halt has exactly one execute cycle (state 3), with the ALU start pulse high, after its fetches.
- R6: With a register destination, the execute cycle is followed by a write cycle (state 4) with the write enable high and the write address equal to the destination address field. With a memory destination there is no register write.
- R7: Opcode 03h (the wide-result opcode) with a register destination adds a second write cycle (state 5) addressed to the pair partner, the destination address with bit 0 inverted.
- R8: Opcode 00h (NOP) returns to state 0 directly after its two fetches, with no operand fetch, execute pulse or write, whatever its type fields hold.
- R9: Opcode 1Fh enters state 6 after its two fetches. The halted output is then high, the read strobe stays low and the address stays fixed until reset.
- R10: State codes are 0 fetch-high, 1 fetch-low, 2 operand, 3 execute, 4 first write, 5 second write, 6 halt. An instruction lasts 2 + operand + execute + writes cycles, and the next one starts at address 2 + operand bytes past its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each state lasts one rising-edge period |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 8 | Byte returned by memory for the current address |
| mem_addr | output | 16 | Program counter, used as the read address |
| mem_rd | output | 1 | Read strobe for fetch and operand cycles |
| ir_out | output | 16 | Assembled instruction word |
| opnd_out | output | 8 | Last fetched operand byte |
| alu_go | output | 1 | ALU start pulse in the execute cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write address |
| state_out | output | 3 | State indicator code |
| halted | output | 1 | High while stopped by the halt opcode |

## Verification
Two functions share the second fetch cycle. The low instruction byte is captured while the route (NOP, halt, operand fetch or execute) is chosen from the high byte captured one cycle earlier. A mix-up between the two bytes would change the route without disturbing the fetches. The bench sweeps every opcode against every source-type and destination-type combination and puts a different pattern in the low byte each time. It judges each case by the cycle count, the address of the next fetch, the execute and write pulse counts and the write addresses, all worked out arithmetically from the field values. Reset is also dropped between clock edges in the middle of an instruction, to confirm that it takes effect at once.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_FETCH_HI = 3'd0,
    ST_FETCH_LO = 3'd1,
    ST_OPERAND  = 3'd2,
    ST_EXEC     = 3'd3,
    ST_WRITE_A  = 3'd4,
    ST_WRITE_B  = 3'd5,
    ST_HALT     = 3'd6
  } seq_state_e;

  localparam logic [4:0] OPC_NOP  = 5'h00;
  localparam logic [4:0] OPC_HALT = 5'h1F;

  // Operand byte needed: memory or immediate source, or memory destination.
  function automatic logic needs_operand(input logic [1:0] src_type,
                                         input logic dst_type);
    return (src_type == 2'b01) || (src_type == 2'b10) || dst_type;
  endfunction

  // Other half of a register pair.
  function automatic logic [2:0] pair_partner(input logic [2:0] addr);
    return {addr[2:1], ~addr[0]};
  endfunction

endpackage

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [AW-1:0] pc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (inc) pc <= pc + 1'b1;
  end

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> pc == $past(pc) + 1'b1);

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(pc));

endmodule

// File: rtl/seq_ir.sv
module seq_ir #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   din,
  input  logic            ld_hi,
  input  logic            ld_lo,
  input  logic            ld_opnd,
  output logic [2*DW-1:0] ir,
  output logic [DW-1:0]   opnd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir   <= '0;
      opnd <= '0;
    end else begin
      if (ld_hi)   ir[2*DW-1:DW] <= din;
      if (ld_lo)   ir[DW-1:0]    <= din;
      if (ld_opnd) opnd          <= din;
    end
  end

  // R2
  ir_one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ld_hi, ld_lo, ld_opnd}) <= 1);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int         DW          = 8,
  parameter logic [4:0] WIDE_OPCODE = 5'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ir_hi,
  input  logic [2:0]    dst_addr,
  output seq_state_e    state,
  output logic          mem_rd,
  output logic          ld_hi,
  output logic          ld_lo,
  output logic          ld_opnd,
  output logic          alu_go,
  output logic          rf_we,
  output logic [2:0]    rf_waddr
);

  // Decoded fields from the high instruction byte.
  logic [4:0] opcode;
  logic [1:0] src_type;
  logic       dst_mem;
  logic       is_nop, is_halt, is_wide, want_opnd;

  assign opcode    = ir_hi[DW-1:DW-5];
  assign src_type  = ir_hi[2:1];
  assign dst_mem   = ir_hi[0];
  assign is_nop    = (opcode == OPC_NOP);
  assign is_halt   = (opcode == OPC_HALT);
  assign is_wide   = (opcode == WIDE_OPCODE);
  assign want_opnd = needs_operand(src_type, dst_mem);

  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FETCH_HI: nxt = ST_FETCH_LO;
      ST_FETCH_LO: begin
        if (is_nop)         nxt = ST_FETCH_HI;
        else if (is_halt)   nxt = ST_HALT;
        else if (want_opnd) nxt = ST_OPERAND;
        else                nxt = ST_EXEC;
      end
      ST_OPERAND:  nxt = ST_EXEC;
      ST_EXEC:     nxt = dst_mem ? ST_FETCH_HI : ST_WRITE_A;
      ST_WRITE_A:  nxt = is_wide ? ST_WRITE_B : ST_FETCH_HI;
      ST_WRITE_B:  nxt = ST_FETCH_HI;
      ST_HALT:     nxt = ST_HALT;
      default:     nxt = ST_FETCH_HI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH_HI;
    else        state <= nxt;
  end

  assign ld_hi    = (state == ST_FETCH_HI);
  assign ld_lo    = (state == ST_FETCH_LO);
  assign ld_opnd  = (state == ST_OPERAND);
  assign mem_rd   = ld_hi | ld_lo | ld_opnd;
  assign alu_go   = (state == ST_EXEC);
  assign rf_we    = (state == ST_WRITE_A) || (state == ST_WRITE_B);
  assign rf_waddr = (state == ST_WRITE_B) ? pair_partner(dst_addr) : dst_addr;

  // R2
  fetch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH_HI |=> state == ST_FETCH_LO);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT |=> state == ST_HALT && !mem_rd);

  // R5
  exec_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go |=> !alu_go);

  // R6
  write_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WRITE_A |-> $past(alu_go));

  // R7
  pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WRITE_B |-> $past(state) == ST_WRITE_A && rf_waddr != $past(rf_waddr));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, alu_go, rf_we}));

endmodule

// File: rtl/instr_seq.sv
module instr_seq
  import seq_pkg::*;
#(
  parameter int         AW          = 16,
  parameter int         DW          = 8,
  parameter logic [4:0] WIDE_OPCODE = 5'h03
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic [2*DW-1:0] ir_out,
  output logic [DW-1:0]   opnd_out,
  output logic            alu_go,
  output logic            rf_we,
  output logic [2:0]      rf_waddr,
  output logic [2:0]      state_out,
  output logic            halted
);

  localparam int IW = 2 * DW;

  seq_state_e state;
  logic       ld_hi, ld_lo, ld_opnd;
  logic [IW-1:0] ir;

  seq_ctrl #(.DW(DW), .WIDE_OPCODE(WIDE_OPCODE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_hi    (ir[IW-1:DW]),
    .dst_addr (ir[4:2]),
    .state    (state),
    .mem_rd   (mem_rd),
    .ld_hi    (ld_hi),
    .ld_lo    (ld_lo),
    .ld_opnd  (ld_opnd),
    .alu_go   (alu_go),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr)
  );

  seq_pc #(.AW(AW)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (mem_rd),
    .pc    (mem_addr)
  );

  seq_ir #(.DW(DW)) u_ir (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (mem_rdata),
    .ld_hi   (ld_hi),
    .ld_lo   (ld_lo),
    .ld_opnd (ld_opnd),
    .ir      (ir),
    .opnd    (opnd_out)
  );

  assign ir_out    = ir;
  assign state_out = state;
  assign halted    = (state == ST_HALT);

  // R9
  halt_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(mem_addr));

endmodule

// File: tb/sim_instr_seq.sv
module sim_instr_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem [0:255];
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, alu_go, rf_we, halted;
  logic [15:0] ir_out;
  logic [7:0]  opnd_out;
  logic [2:0]  rf_waddr, state_out;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  instr_seq u0 (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .ir_out(ir_out), .opnd_out(opnd_out), .alu_go(alu_go),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .state_out(state_out), .halted(halted)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
  endtask

  // Reset, then release at a falling edge; sample point just after.
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 addr in reset", int'(mem_addr), 0);
    check("R1 state in reset", int'(state_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 first strobe", int'(mem_rd), 1);
    check("R1 first addr", int'(mem_addr), 0);
  endtask

  task automatic run_one(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] ob);
    int op, srct, dstm, nop, need, wide, writes, cycles, nxt;
    int cyc, n_alu, n_we;
    int wa [0:3];
    clear_mem();
    mem[0] = hi; mem[1] = lo; mem[2] = ob;
    op = int'(hi[7:3]); srct = int'(hi[2:1]); dstm = int'(hi[0]);
    nop = (op == 0) ? 1 : 0;
    need = (!nop && (srct == 1 || srct == 2 || dstm == 1)) ? 1 : 0;
    wide = (op == 3) ? 1 : 0;
    writes = (nop || dstm) ? 0 : (wide ? 2 : 1);
    cycles = 2 + need + (nop ? 0 : 1) + writes;
    nxt = 2 + need;
    do_reset();
    cyc = 0; n_alu = 0; n_we = 0;
    do begin
      if (alu_go) n_alu++;
      if (rf_we) begin
        if (n_we < 4) wa[n_we] = int'(rf_waddr);
        n_we++;
      end
      cyc++;
      @(negedge clk);
      #1;
    end while (!(state_out == 3'd0 && int'(mem_addr) == nxt) && cyc < 30);
    check($sformatf("R3 R10 cycles hi=%02h", hi), cyc, cycles);
    check($sformatf("R5 R8 exec pulses hi=%02h", hi), n_alu, nop ? 0 : 1);
    check($sformatf("R6 write count hi=%02h", hi), n_we, writes);
    if (writes >= 1) check($sformatf("R6 write addr hi=%02h", hi), wa[0], int'(lo[4:2]));
    if (writes == 2) check($sformatf("R7 partner addr hi=%02h", hi), wa[1], int'(lo[4:2]) ^ 1);
    check($sformatf("R2 ir word hi=%02h", hi), int'(ir_out), int'({hi, lo}));
    if (need) check($sformatf("R4 operand hi=%02h", hi), int'(opnd_out), int'(ob));
    check($sformatf("R2 next fetch strobe hi=%02h", hi), int'(mem_rd), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] hi, lo;
    clear_mem();
    repeat (2) @(negedge clk);

    // Sweep every non-halt opcode against all type fields.
    for (int op = 0; op < 31; op++)
      for (int st = 0; st < 4; st++)
        for (int dm = 0; dm < 2; dm++) begin
          hi = {op[4:0], st[1:0], dm[0]};
          lo = 8'(op * 29 + st * 7 + dm * 3 + 1);
          run_one(hi, lo, ~lo);
        end

    // Halt with every type field combination: no operand, frozen address.
    for (int t = 0; t < 8; t++) begin
      clear_mem();
      mem[0] = {5'h1F, t[2:0]}; mem[1] = 8'h55; mem[2] = 8'hF8;
      do_reset();
      repeat (3) @(negedge clk);
      #1;
      check("R9 halt state", int'(state_out), 6);
      check("R9 halted flag", int'(halted), 1);
      check("R9 halt addr", int'(mem_addr), 2);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); #1;
        check("R9 no strobe", int'(mem_rd), 0);
        check("R9 addr frozen", int'(mem_addr), 2);
      end
    end

    // Back-to-back program: ADD imm, MUL reg, NOP, HALT.
    clear_mem();
    mem[0] = {5'h01, 2'b10, 1'b0}; mem[1] = 8'b000_011_00; mem[2] = 8'h3C;
    mem[3] = {5'h03, 2'b00, 1'b0}; mem[4] = 8'b001_101_00;
    mem[5] = 8'h00; mem[6] = 8'h00;
    mem[7] = 8'hF8; mem[8] = 8'h00;
    do_reset();
    repeat (20) @(negedge clk);
    #1;
    check("R10 program end addr", int'(mem_addr), 9);
    check("R9 program halted", int'(halted), 1);
    check("R2 last ir", int'(ir_out), 16'hF800);
    check("R4 operand kept", int'(opnd_out), 8'h3C);

    // Asynchronous reset between edges, mid-instruction.
    do_reset();
    @(posedge clk); @(posedge clk); @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check("R1 async addr", int'(mem_addr), 0);
    check("R1 async state", int'(state_out), 0);
    check("R1 async no exec", int'(alu_go), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 restart strobe", int'(mem_rd), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule